// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt request lines, ranks them with a fixed priority (line 0 highest), and raises a single interrupt output towards the processor. When the processor pulses the acknowledge input, the block presents an 8-bit vector for the winning line and records that line as in service. In-service levels block lower-priority requests until software retires them with an end-of-interrupt command, or until the automatic end-of-interrupt mode makes that step unnecessary.

Software reaches the block through a byte-wide register port with one select bit. Select 0 is the command port and select 1 is the data port. A command byte with bit 4 set starts a configuration sequence. The state machine `pic_init_seq` moves from ST_READY to ST_WAIT_BASE. The first data write after that stores the vector base. The state then goes to ST_WAIT_CASC when a cascade word is due, to ST_WAIT_MODE when only a mode word is due, or back to ST_READY when neither is due. ST_WAIT_CASC goes on to ST_WAIT_MODE or to ST_READY. ST_WAIT_MODE always returns to ST_READY. A new start command takes the machine to ST_WAIT_BASE from any state. In ST_READY, data writes load the mask and command bytes act as status-select or end-of-interrupt commands. The cascade word is only reported on an output. No cascade bus is driven.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_out` is 0, the mask reads 0xFF on the data port, and the command port reads the request register, which is 0x00.
- R2: A command write with bit 4 set starts configuration. The data writes that follow are taken in order: the base word; then the cascade word, unless bit 1 of the start byte was 1; then the mode word, but only if bit 0 of the start byte was 1. The cascade word appears on `casc_cfg` and is kept when a sequence skips it.
- R3: The vector is `{base[7:3], n}` for granted line n. For example, a base of 0x20 gives 0x20 to 0x27.
- R4: In the ready state, a data write loads the mask, and a 1 bit masks that line. A data-port read returns the mask. Data writes during configuration leave the mask unchanged.
- R5: A rising edge on a line sets its request bit. The bit clears if the line falls, or when an acknowledge grants that line. Masked lines still record requests.
- R6: `irq_out` is 1 exactly when some unmasked request bit has a lower index (higher priority) than every set in-service bit.
- R7: Outside automatic mode, an acknowledge that grants line n sets in-service bit n.
- R8: Command 0x0A selects the request register and 0x0B selects the in-service register for command-port reads. The choice persists, and a start command restores the request register.
- R9: Command 0x60+n clears only in-service bit n.
- R10: Command 0x20 clears the lowest-index set in-service bit.
- R11: When bit 1 of the mode word is 1 (automatic mode), an acknowledge sets no in-service bit.
- R12: An acknowledge with no eligible request returns `{base, 3'd7}` and leaves the in-service register unchanged.
- R13: When an end-of-interrupt command and a granting acknowledge occur in the same cycle, the clear is applied first and the grant's in-service bit is then set.
- R14: A start command clears the in-service register and turns automatic mode off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | 0 selects the command port, 1 selects the data port |
| cpu_wr | input | 1 | Write strobe, one cycle per byte |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the selected port (combinational) |
| irq_in | input | 8 | Interrupt request lines |
| irq_ack | input | 1 | Acknowledge pulse from the processor |
| irq_out | output | 1 | Interrupt request to the processor |
| irq_vector | output | 8 | Vector, valid while `irq_ack` is high |
| casc_cfg | output | 8 | Stored cascade configuration word |

## Verification
An end-of-interrupt command and a granting acknowledge can both fall in the same cycle, and both modify the in-service register. The bench forces this case: it holds line 4 in service, raises line 2, and then drives the acknowledge together with command 0x64 on one clock. The result is correct only if the in-service readback shows bit 2 alone set, meaning the clear of bit 4 and the set of bit 2 were both applied. The behavioural model in the bench also compares every cycle, so any other overlap of a write with an acknowledge is judged in the same way.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int IRQ_N  = 8;
    localparam int IDX_W  = $clog2(IRQ_N);
    localparam int BASE_W = 8 - IDX_W;

    localparam logic [7:0] CMD_SEL_REQ  = 8'h0A;
    localparam logic [7:0] CMD_SEL_SVC  = 8'h0B;
    localparam logic [7:0] CMD_EOI_ANY  = 8'h20;
    localparam logic [4:0] CMD_EOI_LVL  = 5'b01100;

    typedef enum logic [1:0] {
        ST_READY,
        ST_WAIT_BASE,
        ST_WAIT_CASC,
        ST_WAIT_MODE
    } init_state_t;

    typedef enum logic {
        RD_REQUEST,
        RD_SERVICE
    } rd_sel_t;

    function automatic logic [IDX_W-1:0] top_index(input logic [IRQ_N-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = IRQ_N - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              data_wr,
    input  logic [7:0]        wdata,
    output logic [BASE_W-1:0] base,
    output logic [7:0]        casc,
    output logic              aeoi,
    output logic              ready
);
    init_state_t state, state_nx;
    logic        need_casc, need_mode;

    always_comb begin
        state_nx = state;
        if (start_wr) begin
            state_nx = ST_WAIT_BASE;
        end else if (data_wr) begin
            unique case (state)
                ST_READY:     state_nx = ST_READY;
                ST_WAIT_BASE: state_nx = need_casc ? ST_WAIT_CASC
                                       : (need_mode ? ST_WAIT_MODE : ST_READY);
                ST_WAIT_CASC: state_nx = need_mode ? ST_WAIT_MODE : ST_READY;
                ST_WAIT_MODE: state_nx = ST_READY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            need_casc <= 1'b0;
            need_mode <= 1'b0;
            base      <= '0;
            casc      <= '0;
            aeoi      <= 1'b0;
        end else if (start_wr) begin
            need_casc <= ~wdata[1];
            need_mode <= wdata[0];
            aeoi      <= 1'b0;
        end else if (data_wr) begin
            unique case (state)
                ST_READY:     ;
                ST_WAIT_BASE: base <= wdata[7:IDX_W];
                ST_WAIT_CASC: casc <= wdata;
                ST_WAIT_MODE: aeoi <= wdata[1];
            endcase
        end
    end

    assign ready = (state == ST_READY);

    AST_START_ENTERS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> state == ST_WAIT_BASE); // R2
    AST_BASE_TAKEN_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !start_wr && state == ST_WAIT_BASE) |=> state != ST_WAIT_BASE); // R2
    AST_MODE_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !start_wr && state == ST_WAIT_MODE) |=> ready); // R2
    AST_START_DROPS_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> !aeoi); // R14
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch
    import pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_N-1:0] lines,
    input  logic [IRQ_N-1:0] take_mask,
    output logic [IRQ_N-1:0] irr
);
    logic [IRQ_N-1:0] prev;
    logic [IRQ_N-1:0] rise;

    assign rise = lines & ~prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '0;
            irr  <= '0;
        end else begin
            prev <= lines;
            irr  <= ((irr & lines) | rise) & ~take_mask;
        end
    end

    AST_REQ_FOLLOWS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irr & ~$past(lines)) == '0); // R5
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve
    import pic_pkg::*;
(
    input  logic [IRQ_N-1:0] irr,
    input  logic [IRQ_N-1:0] imr,
    input  logic [IRQ_N-1:0] isr,
    output logic             grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic [IDX_W-1:0] svc_idx
);
    logic [IRQ_N-1:0] live;

    always_comb begin
        live      = irr & ~imr;
        grant_idx = top_index(live);
        svc_idx   = top_index(isr);
        grant     = (|live) && (!(|isr) || (grant_idx < svc_idx));
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_sel,
    input  logic             cpu_wr,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    input  logic [IRQ_N-1:0] irq_in,
    input  logic             irq_ack,
    output logic             irq_out,
    output logic [7:0]       irq_vector,
    output logic [7:0]       casc_cfg
);
    logic              cmd_wr, dat_wr, start_wr;
    logic              sel_req, sel_svc, eoi_lvl, eoi_any, take;
    logic              ready, aeoi, grant;
    logic [BASE_W-1:0] base;
    logic [IDX_W-1:0]  grant_idx, svc_idx;
    logic [IRQ_N-1:0]  irr, imr, isr, isr_nx, take_mask;
    rd_sel_t           rd_sel;

    always_comb begin
        cmd_wr   = cpu_wr & ~cpu_sel;
        dat_wr   = cpu_wr & cpu_sel;
        start_wr = cmd_wr & cpu_wdata[4];
        sel_req  = cmd_wr && (cpu_wdata == CMD_SEL_REQ);
        sel_svc  = cmd_wr && (cpu_wdata == CMD_SEL_SVC);
        eoi_lvl  = cmd_wr && (cpu_wdata[7:IDX_W] == CMD_EOI_LVL);
        eoi_any  = cmd_wr && (cpu_wdata == CMD_EOI_ANY);
        take     = irq_ack & grant;
        take_mask = take ? (IRQ_N'(1) << grant_idx) : '0;
    end

    pic_init_seq u_init (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .data_wr(dat_wr),
        .wdata(cpu_wdata), .base(base), .casc(casc_cfg), .aeoi(aeoi), .ready(ready)
    );

    pic_req_latch u_req (
        .clk(clk), .rst_n(rst_n), .lines(irq_in), .take_mask(take_mask), .irr(irr)
    );

    pic_prio_resolve u_prio (
        .irr(irr), .imr(imr), .isr(isr),
        .grant(grant), .grant_idx(grant_idx), .svc_idx(svc_idx)
    );

    always_comb begin
        isr_nx = isr;
        if (start_wr) begin
            isr_nx = '0;
        end else begin
            if (eoi_lvl)      isr_nx[cpu_wdata[IDX_W-1:0]] = 1'b0;
            else if (eoi_any) isr_nx[svc_idx] = 1'b0;
            if (!aeoi)        isr_nx = isr_nx | take_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr    <= '0;
            imr    <= '1;
            rd_sel <= RD_REQUEST;
        end else begin
            isr <= isr_nx;
            if (dat_wr && ready) imr <= cpu_wdata;
            if (start_wr || sel_req) rd_sel <= RD_REQUEST;
            else if (sel_svc)        rd_sel <= RD_SERVICE;
        end
    end

    assign cpu_rdata  = cpu_sel ? imr : ((rd_sel == RD_SERVICE) ? isr : irr);
    assign irq_out    = grant;
    assign irq_vector = {base, grant ? grant_idx : IDX_W'(IRQ_N - 1)};

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (irr & ~imr) != '0); // R6
    AST_MASK_HELD_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !ready) |=> $stable(imr)); // R4
    AST_ACK_SETS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !aeoi && !start_wr) |=> isr[$past(grant_idx)]); // R7
    AST_LEVEL_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_lvl && !take) |=> !isr[$past(cpu_wdata[IDX_W-1:0])]); // R9
    AST_AUTO_NO_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        (take && aeoi && !cmd_wr) |=> $stable(isr)); // R11
    AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !grant && !cmd_wr) |=> $stable(isr)); // R12
    AST_START_CLEARS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> isr == '0); // R14
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_sel = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic [7:0] irq_in = 8'h00;
    logic       irq_ack = 1'b0;
    logic       irq_out;
    logic [7:0] irq_vector;
    logic [7:0] casc_cfg;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_NS / 2) clk = ~clk;

    prio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq_in(irq_in),
        .irq_ack(irq_ack), .irq_out(irq_out), .irq_vector(irq_vector),
        .casc_cfg(casc_cfg)
    );

    // Behavioural reference model
    bit [7:0] m_irr, m_isr, m_imr, m_prev, m_casc;
    bit [4:0] m_base;
    bit       m_aeoi, m_svcsel, m_nc, m_nm;
    int       m_phase;

    function automatic int first_set(bit [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_irr = 0; m_isr = 0; m_imr = 8'hFF; m_prev = 0; m_casc = 0;
            m_base = 0; m_aeoi = 0; m_svcsel = 0; m_nc = 0; m_nm = 0; m_phase = 0;
        end else begin
            int g;
            int s;
            bit gv;
            bit old_aeoi;
            bit started;
            bit [7:0] isr_n;
            bit [7:0] irr_n;
            g = first_set(m_irr & ~m_imr);
            s = first_set(m_isr);
            gv = (g < 8) && (g < s);
            old_aeoi = m_aeoi;
            started = 0;
            isr_n = m_isr;
            irr_n = (m_irr & irq_in) | (irq_in & ~m_prev);
            if (cpu_wr && !cpu_sel) begin
                if (cpu_wdata[4]) begin
                    started = 1; m_phase = 1; m_nc = !cpu_wdata[1]; m_nm = cpu_wdata[0];
                    m_aeoi = 0; isr_n = 0; m_svcsel = 0;
                end else if (cpu_wdata == 8'h0A) m_svcsel = 0;
                else if (cpu_wdata == 8'h0B) m_svcsel = 1;
                else if (cpu_wdata >= 8'h60 && cpu_wdata <= 8'h67) isr_n[cpu_wdata - 8'h60] = 0;
                else if (cpu_wdata == 8'h20 && s < 8) isr_n[s] = 0;
            end
            if (cpu_wr && cpu_sel) begin
                case (m_phase)
                    0: m_imr = cpu_wdata;
                    1: begin m_base = cpu_wdata[7:3]; m_phase = m_nc ? 2 : (m_nm ? 3 : 0); end
                    2: begin m_casc = cpu_wdata; m_phase = m_nm ? 3 : 0; end
                    default: begin m_aeoi = cpu_wdata[1]; m_phase = 0; end
                endcase
            end
            if (irq_ack && gv) begin
                irr_n[g] = 0;
                if (!old_aeoi && !started) isr_n[g] = 1;
            end
            m_isr = isr_n;
            m_irr = irr_n;
            m_prev = irq_in;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            int g;
            bit gv;
            g = first_set(m_irr & ~m_imr);
            gv = (g < 8) && (g < first_set(m_isr));
            chk("R6 model irq_out", {7'd0, irq_out}, {7'd0, gv});
            chk("R2 model casc_cfg", casc_cfg, m_casc);
            chk("R8 model readback", cpu_rdata,
                cpu_sel ? m_imr : (m_svcsel ? m_isr : m_irr));
            if (irq_ack)
                chk("R3 model vector", irq_vector, {m_base, gv ? 3'(g) : 3'd7});
        end
    end

    task automatic wr(bit sel, bit [7:0] d);
        @(negedge clk);
        cpu_sel = sel; cpu_wr = 1'b1; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic ack(output logic [7:0] v);
        @(negedge clk);
        irq_ack = 1'b1;
        #1 v = irq_vector;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic rd(bit sel, output logic [7:0] d);
        cpu_sel = sel;
        #1 d = cpu_rdata;
    endtask

    task automatic lines(bit [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq_out after reset", {7'd0, irq_out}, 8'h00);
        rd(1, d); chk("R1 mask after reset", d, 8'hFF);
        rd(0, d); chk("R1 request readback after reset", d, 8'h00);

        wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
        chk("R2 cascade word stored", casc_cfg, 8'h04);
        rd(1, d); chk("R4 mask untouched by config", d, 8'hFF);

        lines(8'h08);
        chk("R4 masked line gives no irq", {7'd0, irq_out}, 8'h00);
        rd(0, d); chk("R5 masked request recorded", d, 8'h08);
        wr(1, 8'h00);
        rd(1, d); chk("R4 mask readback", d, 8'h00);
        chk("R6 irq on unmasked request", {7'd0, irq_out}, 8'h01);
        ack(d); chk("R3 vector for line 3", d, 8'h23);
        chk("R5 request cleared by ack", {7'd0, irq_out}, 8'h00);
        wr(0, 8'h0B);
        rd(0, d); chk("R7 in-service after ack", d, 8'h08);

        lines(8'h0A);
        chk("R6 higher level nests", {7'd0, irq_out}, 8'h01);
        lines(8'h2A);
        ack(d); chk("R3 vector for line 1", d, 8'h21);
        rd(0, d); chk("R8 service select persists", d, 8'h0A);
        chk("R6 lower level held off", {7'd0, irq_out}, 8'h00);

        wr(0, 8'h61);
        rd(0, d); chk("R9 level EOI clears bit 1 only", d, 8'h08);
        chk("R6 line 5 still outranked", {7'd0, irq_out}, 8'h00);
        wr(0, 8'h20);
        rd(0, d); chk("R10 plain EOI clears top bit", d, 8'h00);
        chk("R6 line 5 now wins", {7'd0, irq_out}, 8'h01);
        ack(d); chk("R3 vector for line 5", d, 8'h25);
        wr(0, 8'h0A);
        rd(0, d); chk("R8 request select", d, 8'h00);
        wr(0, 8'h20);

        lines(8'hAA);
        chk("R6 line 7 raises irq", {7'd0, irq_out}, 8'h01);
        lines(8'h2A);
        chk("R5 request drops with line", {7'd0, irq_out}, 8'h00);
        ack(d); chk("R12 spurious vector", d, 8'h27);
        wr(0, 8'h0B);
        rd(0, d); chk("R12 no in-service on spurious", d, 8'h00);

        lines(8'h3A);
        ack(d); chk("R3 vector for line 4", d, 8'h24);
        lines(8'h3E);
        chk("R6 line 2 over line 4", {7'd0, irq_out}, 8'h01);
        @(negedge clk);
        irq_ack = 1'b1; cpu_sel = 1'b0; cpu_wr = 1'b1; cpu_wdata = 8'h64;
        #1 chk("R13 vector in shared cycle", irq_vector, 8'h22);
        @(negedge clk);
        irq_ack = 1'b0; cpu_wr = 1'b0;
        rd(0, d); chk("R13 EOI and grant both applied", d, 8'h04);

        lines(8'h7E);
        chk("R6 line 6 held off by line 2", {7'd0, irq_out}, 8'h00);
        wr(0, 8'h13);
        rd(0, d); chk("R8 start restores request select", d, 8'h40);
        wr(0, 8'h0B);
        rd(0, d); chk("R14 start clears in-service", d, 8'h00);
        wr(1, 8'h40); wr(1, 8'h02);
        chk("R2 skipped cascade word kept", casc_cfg, 8'h04);
        rd(1, d); chk("R4 mask kept through config", d, 8'h00);
        chk("R6 line 6 after restart", {7'd0, irq_out}, 8'h01);
        ack(d); chk("R3 vector with new base", d, 8'h46);
        rd(0, d); chk("R11 automatic mode sets no bit", d, 8'h00);
        chk("R11 irq drops after auto ack", {7'd0, irq_out}, 8'h00);

        wr(1, 8'hFF);
        lines(8'h7F);
        chk("R4 all masked", {7'd0, irq_out}, 8'h00);
        ack(d); chk("R12 spurious with all masked", d, 8'h47);
        rd(0, d); chk("R12 in-service unchanged", d, 8'h00);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule